// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the software-visible state of a single DMA channel: a control/status word, a transfer address, a byte count and an upper-address base word. Each is 32 bits wide and is reached with whole-word reads and writes through a small word-addressed port. The register index comes from the two low bits of the word address, so the four registers repeat across the decoded window. Any word at or beyond the window limit reads as zero and discards writes.

The control word drives the signals to the attached peripheral. It gates the interrupt line to the host. It sends a one-cycle reset pulse to the peripheral and holds a level enable toward the data mover. Writes to the control word have side effects. The fixed version bits and a set of protected status bits never change under software. An all-zero write is turned into a drain request. Writing the address register marks the channel as loaded. A device interrupt level feeds the pending bit, and an advance strobe with a length moves the address register forward after each burst.

Top module: `dmachan_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, the other three registers read 0, and irq_o, periph_rst_o, periph_en_o and rdata_vld are all low.
- R2: The register index is waddr[1:0] (0 control, 1 address, 2 count, 3 base). Words below WIN_WORDS (default 8) alias onto the four registers. Words at or above WIN_WORDS read as 0, and writes to them change nothing.
- R3: A write to index 1, 2 or 3 stores wdata unchanged. A write to index 1 also sets control bit 26 (loaded). Control writes cannot clear bit 26, because it lies under the protection mask.
- R4: On a control write, the bits set in 0xFE000007 keep their previous value. The stored word always has bits 31 and 29 set (version 0xA0000000).
- R5: On a control write the value is transformed before it is stored. If bit 7 is set, the value is kept as written. Otherwise, if bit 6 is set, bit 6 is cleared. Otherwise, if the whole word is zero, it is stored as 0x00000040 (drain request).
- R6: A control write with bit 7 set drives periph_rst_o high for exactly the cycle after the write.
- R7: periph_en_o rises in the cycle after a control write that changes bit 9 from 0 to 1. It falls after a write that changes bit 9 from 1 to 0.
- R8: A rising edge on dev_irq_i sets control bit 0 (pending) one cycle later. A falling edge clears pending one cycle later if it was set.
- R9: irq_o is high exactly when pending (bit 0) and interrupt enable (bit 4) are both set. It follows changes made by control writes as well as by device edges.
- R10: An adv_stb cycle adds adv_len to the address register. If the address register is written in the same cycle, the written value wins.
- R11: rdata_vld is high in the cycle after rd_en is high. rdata is combinational from waddr.
- R12: When a device edge and a control write fall in the same cycle, the pending bit follows the edge. irq_o reflects the newly written enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| rd_en | input | 1 | Word read strobe |
| waddr | input | WA_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from waddr |
| rdata_vld | output | 1 | Read strobe delayed one cycle |
| dev_irq_i | input | 1 | Device interrupt level |
| adv_stb | input | 1 | Burst completed, advance the address |
| adv_len | input | LEN_W | Burst length in bytes |
| irq_o | output | 1 | Interrupt to host |
| periph_rst_o | output | 1 | One-cycle reset pulse to peripheral |
| periph_en_o | output | 1 | DMA enable level to peripheral |

## Verification
The hardest case to reach from the ports is a device interrupt edge that lands in the same cycle as a control write changing the interrupt enable. Two sources then update the pending bit and the interrupt line in one clock. The bench drives the edge and the write on the same falling edge of the clock, then reads back both the pending bit and irq_o. A second hard case is a burst advance that collides with an address write. The bench reaches it by asserting both strobes in one cycle.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

  localparam int DW      = 32;
  localparam int NREGS   = 4;
  localparam int IDX_W   = $clog2(NREGS);

  localparam logic [DW-1:0] CSR_VERSION = 32'hA000_0000;
  localparam logic [DW-1:0] CSR_RO_MASK = 32'hFE00_0007;
  localparam logic [DW-1:0] CSR_DRAIN_V = 32'h0000_0040;

  localparam int B_PEND   = 0;
  localparam int B_IEN    = 4;
  localparam int B_DRAIN  = 6;
  localparam int B_PRST   = 7;
  localparam int B_DEN    = 9;
  localparam int B_LOADED = 26;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 2'd0,
    IDX_ADDR  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_BASE  = 2'd3
  } reg_idx_e;

  // Value stored by a software write to the control word.
  function automatic logic [DW-1:0] csr_store_value(input logic [DW-1:0] old_v,
                                                    input logic [DW-1:0] w);
    logic [DW-1:0] v;
    v = w;
    if (v[B_PRST]) begin
      v = w;
    end else if (v[B_DRAIN]) begin
      v[B_DRAIN] = 1'b0;
    end else if (v == '0) begin
      v = CSR_DRAIN_V;
    end
    return (old_v & CSR_RO_MASK) | (v & ~CSR_RO_MASK) | CSR_VERSION;
  endfunction

  // Address after a burst of len bytes.
  function automatic logic [DW-1:0] addr_advance(input logic [DW-1:0] a,
                                                 input logic [DW-1:0] len);
    return a + len;
  endfunction

endpackage

// File: rtl/dmachan_decode.sv
module dmachan_decode
  import dmachan_pkg::*;
#(
  parameter int WA_W      = 4,
  parameter int WIN_WORDS = 8
) (
  input  logic [WA_W-1:0]  waddr,
  input  logic             wr_en,
  output logic [IDX_W-1:0] idx,
  output logic             in_win,
  output logic [NREGS-1:0] wr_sel
);

  localparam logic [WA_W:0] WIN_LIMIT = (WA_W+1)'(WIN_WORDS);

  assign idx    = waddr[IDX_W-1:0];
  assign in_win = ({1'b0, waddr} < WIN_LIMIT);

  for (genvar i = 0; i < NREGS; i++) begin : g_sel
    assign wr_sel[i] = wr_en && in_win && (idx == IDX_W'(i));
  end

endmodule

// File: rtl/dmachan_irq.sv
module dmachan_irq
  import dmachan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dev_irq_i,
  input  logic csr_wr,
  input  logic wr_ien,
  input  logic pend_q,
  input  logic ien_q,
  output logic pend_set,
  output logic pend_clr,
  output logic irq_o
);

  logic dev_q;
  logic dev_rise;
  logic dev_fall;
  logic irq_d;
  logic ien_eff;

  assign dev_rise = dev_irq_i && !dev_q;
  assign dev_fall = !dev_irq_i && dev_q;
  assign pend_set = dev_rise;
  assign pend_clr = dev_fall && pend_q;
  assign ien_eff  = csr_wr ? wr_ien : ien_q;

  // Software write is applied first, the device edge second.
  always_comb begin
    irq_d = irq_o;
    if (csr_wr) begin
      if (wr_ien) begin
        if (pend_q) irq_d = 1'b1;
      end else if (pend_q || ien_q) begin
        irq_d = 1'b0;
      end
    end
    if (dev_rise && ien_eff) irq_d = 1'b1;
    if (pend_clr && ien_eff) irq_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      dev_q <= dev_irq_i;
      irq_o <= irq_d;
    end
  end

  // R9: interrupt line equals pending AND enable of the stored word
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_q && ien_q));

  // R8: a device rising edge leaves pending set
  a_r8_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rise |=> pend_q);

endmodule

// File: rtl/dmachan_csr.sv
module dmachan_csr
  import dmachan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          loaded_set,
  input  logic          pend_set,
  input  logic          pend_clr,
  output logic [DW-1:0] csr_q,
  output logic          periph_rst_o,
  output logic          periph_en_o
);

  logic [DW-1:0] csr_d;
  logic          en_rise;
  logic          en_fall;

  assign en_rise = wr && wdata[B_DEN] && !csr_q[B_DEN];
  assign en_fall = wr && !wdata[B_DEN] && csr_q[B_DEN];

  always_comb begin
    csr_d = csr_q;
    if (wr)         csr_d = csr_store_value(csr_q, wdata);
    if (loaded_set) csr_d[B_LOADED] = 1'b1;
    if (pend_set)   csr_d[B_PEND] = 1'b1;
    if (pend_clr)   csr_d[B_PEND] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q        <= CSR_VERSION;
      periph_rst_o <= 1'b0;
      periph_en_o  <= 1'b0;
    end else begin
      csr_q        <= csr_d;
      periph_rst_o <= wr && wdata[B_PRST];
      if (en_rise)      periph_en_o <= 1'b1;
      else if (en_fall) periph_en_o <= 1'b0;
    end
  end

  // R4: version bits never drop
  a_r4_version_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q & CSR_VERSION) == CSR_VERSION);

  // R6: reset pulse only follows a write carrying the reset bit
  a_r6_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |-> $past(wr && wdata[B_PRST]));

  // R7: enable level tracks the stored DMA enable bit
  a_r7_en_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    periph_en_o == csr_q[B_DEN]);

  // R3: an address write leaves the loaded flag set
  a_r3_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_set |=> csr_q[B_LOADED]);

endmodule

// File: rtl/dmachan_dreg.sv
module dmachan_dreg
  import dmachan_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [DW-1:0]    wdata,
  input  logic             adv_stb,
  input  logic [LEN_W-1:0] adv_len,
  output logic [DW-1:0]    q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (wr)      q <= wdata;
    else if (adv_stb) q <= addr_advance(q, DW'(adv_len));
  end

  // R3: the word holds without a write or advance
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !adv_stb) |=> $stable(q));

  // R10: an advance without a write adds the length
  a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_stb && !wr) |=> (q == $past(q) + DW'($past(adv_len))));

endmodule

// File: rtl/dmachan_regs.sv
module dmachan_regs
  import dmachan_pkg::*;
#(
  parameter int WA_W      = 4,
  parameter int WIN_WORDS = 8,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WA_W-1:0]  waddr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_vld,
  input  logic             dev_irq_i,
  input  logic             adv_stb,
  input  logic [LEN_W-1:0] adv_len,
  output logic             irq_o,
  output logic             periph_rst_o,
  output logic             periph_en_o
);

  logic [IDX_W-1:0] idx;
  logic             in_win;
  logic [NREGS-1:0] wr_sel;
  logic [DW-1:0]    regs [NREGS];
  logic [DW-1:0]    csr_q;
  logic             pend_set;
  logic             pend_clr;

  dmachan_decode #(.WA_W(WA_W), .WIN_WORDS(WIN_WORDS)) u_dec (
    .waddr  (waddr),
    .wr_en  (wr_en),
    .idx    (idx),
    .in_win (in_win),
    .wr_sel (wr_sel)
  );

  dmachan_csr u_csr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (wr_sel[IDX_CTRL]),
    .wdata        (wdata),
    .loaded_set   (wr_sel[IDX_ADDR]),
    .pend_set     (pend_set),
    .pend_clr     (pend_clr),
    .csr_q        (csr_q),
    .periph_rst_o (periph_rst_o),
    .periph_en_o  (periph_en_o)
  );

  dmachan_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq_i (dev_irq_i),
    .csr_wr    (wr_sel[IDX_CTRL]),
    .wr_ien    (wdata[B_IEN]),
    .pend_q    (csr_q[B_PEND]),
    .ien_q     (csr_q[B_IEN]),
    .pend_set  (pend_set),
    .pend_clr  (pend_clr),
    .irq_o     (irq_o)
  );

  assign regs[0] = csr_q;

  for (genvar i = 1; i < NREGS; i++) begin : g_dreg
    dmachan_dreg #(.LEN_W(LEN_W)) u_dreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_sel[i]),
      .wdata   (wdata),
      .adv_stb ((i == int'(IDX_ADDR)) ? adv_stb : 1'b0),
      .adv_len (adv_len),
      .q       (regs[i])
    );
  end

  assign rdata = in_win ? regs[idx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_vld <= 1'b0;
    else        rdata_vld <= rd_en;
  end

  // R11: read strobe reported one cycle later
  a_r11_vld: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rdata_vld);

  // R2: words outside the window read as zero
  a_r2_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> (rdata == '0));

endmodule

// File: tb/dmachan_regs_bench.sv
module dmachan_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WA_W  = 4;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             rd_en = 1'b0;
  logic [WA_W-1:0]  waddr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic             rdata_vld;
  logic             dev_irq_i = 1'b0;
  logic             adv_stb = 1'b0;
  logic [LEN_W-1:0] adv_len = '0;
  logic             irq_o;
  logic             periph_rst_o;
  logic             periph_en_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmachan_regs #(.WA_W(WA_W), .WIN_WORDS(8), .LEN_W(LEN_W)) u_dmachan_regs (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .waddr (waddr), .wdata (wdata), .rdata (rdata), .rdata_vld (rdata_vld),
    .dev_irq_i (dev_irq_i), .adv_stb (adv_stb), .adv_len (adv_len),
    .irq_o (irq_o), .periph_rst_o (periph_rst_o), .periph_en_o (periph_en_o)
  );

  typedef struct packed {
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  // Writes applied in order; state carries from one row to the next.
  localparam vec_t VECS [12] = '{
    '{4'd2,  32'h0000_1234, 4'd2, 32'h0000_1234, 8'd3},  // R3 count
    '{4'd3,  32'hFF00_0000, 4'd3, 32'hFF00_0000, 8'd3},  // R3 base
    '{4'd1,  32'h0010_0000, 4'd0, 32'hA400_0000, 8'd3},  // R3 loaded
    '{4'd9,  32'h0000_DEAD, 4'd1, 32'h0010_0000, 8'd2},  // R2 outside ignored
    '{4'd5,  32'h0000_0800, 4'd1, 32'h0000_0800, 8'd2},  // R2 alias
    '{4'd0,  32'h0000_0000, 4'd0, 32'hA400_0040, 8'd5},  // R5 zero -> drain
    '{4'd0,  32'h0000_0040, 4'd0, 32'hA400_0000, 8'd5},  // R5 drain cleared
    '{4'd0,  32'h0000_00C0, 4'd0, 32'hA400_00C0, 8'd5},  // R5 reset keeps
    '{4'd0,  32'hFFFF_FFFF, 4'd0, 32'hA5FF_FFF8, 8'd4},  // R4 protected bits
    '{4'd0,  32'h0000_0010, 4'd0, 32'hA400_0010, 8'd4},  // R4 version kept
    '{4'd15, 32'h0000_0001, 4'd15, 32'h0000_0000, 8'd2}, // R2 outside reads 0
    '{4'd7,  32'h0000_0005, 4'd3, 32'h0000_0005, 8'd2}   // R2 alias base
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    waddr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
    waddr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    do_rd(4'd0, d); chk("R1 ctrl", d, 32'hA000_0000);
    do_rd(4'd1, d); chk("R1 addr", d, 32'h0);
    do_rd(4'd2, d); chk("R1 count", d, 32'h0);
    do_rd(4'd3, d); chk("R1 base", d, 32'h0);
    chk("R1 outputs", {28'd0, irq_o, periph_rst_o, periph_en_o, rdata_vld}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      do_wr(VECS[i].wa, VECS[i].wd);
      do_rd(VECS[i].ra, d);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // R11 read valid timing
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 vld high", {31'd0, rdata_vld}, 32'd1);
    @(negedge clk);
    chk("R11 vld low", {31'd0, rdata_vld}, 32'd0);

    // R6 reset pulse one cycle
    do_wr(4'd0, 32'h0000_0080);
    chk("R6 pulse", {31'd0, periph_rst_o}, 32'd1);
    @(negedge clk);
    chk("R6 pulse end", {31'd0, periph_rst_o}, 32'd0);

    // R7 enable level
    do_wr(4'd0, 32'h0000_0200);
    chk("R7 en rise", {31'd0, periph_en_o}, 32'd1);
    do_wr(4'd0, 32'h0000_0000);
    chk("R7 en fall", {31'd0, periph_en_o}, 32'd0);

    // R8 / R9 interrupt path
    do_wr(4'd0, 32'h0000_0010);
    @(negedge clk); dev_irq_i = 1'b1;
    @(negedge clk);
    chk("R9 irq on rise", {31'd0, irq_o}, 32'd1);
    do_rd(4'd0, d); chk("R8 pending set", {31'd0, d[0]}, 32'd1);
    do_wr(4'd0, 32'h0000_0001);
    chk("R9 irq masked", {31'd0, irq_o}, 32'd0);
    do_rd(4'd0, d); chk("R8 pending kept", {31'd0, d[0]}, 32'd1);
    do_wr(4'd0, 32'h0000_0010);
    chk("R9 irq unmasked", {31'd0, irq_o}, 32'd1);
    @(negedge clk); dev_irq_i = 1'b0;
    @(negedge clk);
    chk("R9 irq on fall", {31'd0, irq_o}, 32'd0);
    do_rd(4'd0, d); chk("R8 pending clear", {31'd0, d[0]}, 32'd0);

    // R12 edge and enable write in the same cycle
    do_wr(4'd0, 32'h0000_0001);
    @(negedge clk);
    dev_irq_i = 1'b1; waddr = 4'd0; wdata = 32'h0000_0010; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R12 irq", {31'd0, irq_o}, 32'd1);
    do_rd(4'd0, d); chk("R12 pending", d, 32'hA400_0011);
    @(negedge clk); dev_irq_i = 1'b0;
    @(negedge clk);

    // R10 address advance
    do_wr(4'd1, 32'h0000_0100);
    @(negedge clk); adv_stb = 1'b1; adv_len = 16'h0020;
    @(negedge clk); adv_stb = 1'b0;
    do_rd(4'd1, d); chk("R10 advance", d, 32'h0000_0120);
    @(negedge clk);
    adv_stb = 1'b1; adv_len = 16'h0004; waddr = 4'd1; wdata = 32'h0000_0500; wr_en = 1'b1;
    @(negedge clk);
    adv_stb = 1'b0; wr_en = 1'b0;
    do_rd(4'd1, d); chk("R10 write wins", d, 32'h0000_0500);
    @(negedge clk); adv_stb = 1'b1; adv_len = 16'hFFFF;
    @(negedge clk); adv_stb = 1'b0;
    do_rd(4'd1, d); chk("R10 wide len", d, 32'h0001_04FF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule